// File: doc/BRIEF.md
# AES-128 Key-Expansion Word Assist

This unit prepares the two word forms that an AES-128 key-expansion step needs. It takes a 128-bit source operand and an 8-bit round constant. It picks out the odd 32-bit words of the source (words 1 and 3) and passes each byte of them through the forward AES substitution box. For each of these words it returns two results: the plain substituted word, and a copy rotated right by one byte with the round constant XORed into its lowest byte. The even source words play no part. Mixing these words into the running key schedule is left to the surrounding logic.

The S-box is not stored as a table. Each byte lane computes it from the multiplicative inverse in GF(2^8) followed by the affine transform. A two-state controller registers the result and raises a valid flag one cycle after each accepted input.

Byte i of a 128-bit vector is bits [8i+7:8i]. Word k is bits [32k+31:32k].

The controller has two states. In `KX_IDLE` no result is pending. In `KX_LOADED` a fresh result was captured on the last edge. The transitions are:
- ACCEPT: `KX_IDLE` to `KX_LOADED` on `in_valid`.
- STREAM: `KX_LOADED` to `KX_LOADED` on `in_valid`.
- DRAIN: `KX_LOADED` to `KX_IDLE` without `in_valid`.
- WAIT: `KX_IDLE` to `KX_IDLE` without `in_valid`.

Top module: `kexp_assist`

## Requirements
- R1: Result bytes 0..3 are the S-box images of source bytes 4..7, each in the same byte position order.
- R2: Result bytes 8..11 are the S-box images of source bytes 12..15, in the same order.
- R3: Result word 1 is result word 0 rotated right by 8 bits (byte 0 moves to byte 3), XORed with the zero-extended round constant.
- R4: Result word 3 is result word 2 rotated right by 8 bits, XORed with the zero-extended round constant. For the standard AES-128 test key with constant 0x01, word 3 equals 0x01EB848B, which is bytes 8B,84,EB,01 in byte order.
- R5: The substitution is the standard AES forward S-box, for example 0x00 maps to 0x63, 0x01 to 0x7C, 0xFF to 0x16 and 0x53 to 0xED.
- R6: The round constant reaches only the lowest byte of words 1 and 3. The upper three bytes of those words do not depend on it.
- R7: Source words 0 and 2 have no effect on the result.
- R8: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. The result register loads only on `in_valid` and holds otherwise.
- R9: After reset, `out_valid` is 0, the result is all zeros and the controller is in `KX_IDLE`.
- R10: The controller follows ACCEPT, STREAM, DRAIN and WAIT as described above, so a stream of back-to-back inputs gives back-to-back valid results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Source and constant are valid this cycle |
| in_src | input | 128 | Source operand |
| in_rcon | input | 8 | Round constant |
| out_valid | output | 1 | Result was loaded on the last edge |
| out_result | output | 128 | Registered result |

## Verification
The bench builds the unit with its default parameters: two lanes of four 8-bit bytes and an 8-bit round constant. This is the exact AES-128 shape, so the standard test key can be applied directly, and the first expansion step's temporary word can be checked against its published value. The vectors reach the S-box corners 0x00 and 0xFF and a back-to-back stream through the STREAM transition. A constant of 0xFF against 0x00 exposes any leak beyond the lowest byte. Pairs of sources that differ only in the even words confirm that those words are ignored.

// File: rtl/kexp_pkg.sv
package kexp_pkg;

    localparam logic [7:0] AFFINE_C = 8'h63;
    localparam logic [7:0] GF_POLY  = 8'h1b;

    typedef enum logic [0:0] {
        KX_IDLE   = 1'b0,
        KX_LOADED = 1'b1
    } kx_state_t;

    // Product in GF(2^8) modulo x^8+x^4+x^3+x+1
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] x;
        acc = 8'h00;
        x   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ x;
            x = {x[6:0], 1'b0} ^ (x[7] ? GF_POLY : 8'h00);
        end
        return acc;
    endfunction

    // Inverse as a^254; zero maps to zero
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] sq;
        logic [7:0] r;
        sq = a;
        r  = 8'h01;
        for (int i = 1; i < 8; i++) begin
            sq = gf_mul(sq, sq);
            r  = gf_mul(r, sq);
        end
        return r;
    endfunction

    function automatic logic [7:0] affine(input logic [7:0] v);
        logic [7:0] b;
        for (int i = 0; i < 8; i++) begin
            b[i] = v[i] ^ v[(i + 4) % 8] ^ v[(i + 5) % 8] ^
                   v[(i + 6) % 8] ^ v[(i + 7) % 8] ^ AFFINE_C[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/kexp_sbox.sv
module kexp_sbox
    import kexp_pkg::*;
(
    input  logic [7:0] in_byte,
    output logic [7:0] out_byte
);
    always_comb begin
        out_byte = affine(gf_inv(in_byte));
    end
endmodule

// File: rtl/kexp_lane.sv
module kexp_lane #(
    parameter int BYTE_W     = 8,
    parameter int WORD_BYTES = 4,
    parameter int RCON_W     = 8
) (
    input  logic [WORD_BYTES*BYTE_W-1:0] src_word,
    input  logic [RCON_W-1:0]            rcon,
    output logic [WORD_BYTES*BYTE_W-1:0] sub_word,
    output logic [WORD_BYTES*BYTE_W-1:0] rot_word
);
    localparam int WORD_W = WORD_BYTES * BYTE_W;
    localparam int PAD_W  = WORD_W - RCON_W;

    for (genvar b = 0; b < WORD_BYTES; b++) begin : g_byte
        kexp_sbox u_sbox (
            .in_byte  (src_word[b*BYTE_W +: BYTE_W]),
            .out_byte (sub_word[b*BYTE_W +: BYTE_W])
        );
    end

    always_comb begin
        rot_word = {sub_word[BYTE_W-1:0], sub_word[WORD_W-1:BYTE_W]}
                 ^ {{PAD_W{1'b0}}, rcon};
    end
endmodule

// File: rtl/kexp_assist.sv
module kexp_assist
    import kexp_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int WORD_BYTES = 4,
    parameter int LANES      = 2,
    parameter int RCON_W     = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  in_valid,
    input  logic [2*LANES*WORD_BYTES*BYTE_W-1:0]  in_src,
    input  logic [RCON_W-1:0]                     in_rcon,
    output logic                                  out_valid,
    output logic [2*LANES*WORD_BYTES*BYTE_W-1:0]  out_result
);
    localparam int WORD_W = WORD_BYTES * BYTE_W;
    localparam int DATA_W = 2 * LANES * WORD_W;

    kx_state_t          state_q;
    kx_state_t          state_d;
    logic [DATA_W-1:0]  next_result;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam int SUB_LO = 2 * l * WORD_W;
        localparam int ROT_LO = (2 * l + 1) * WORD_W;

        kexp_lane #(
            .BYTE_W     (BYTE_W),
            .WORD_BYTES (WORD_BYTES),
            .RCON_W     (RCON_W)
        ) u_lane (
            .src_word (in_src[ROT_LO +: WORD_W]),
            .rcon     (in_rcon),
            .sub_word (next_result[SUB_LO +: WORD_W]),
            .rot_word (next_result[ROT_LO +: WORD_W])
        );

        // R3 R4 R6: upper bytes of the rotated word track the plain word only
        upper_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> out_result[ROT_LO+WORD_W-1 : ROT_LO+BYTE_W] ==
                {out_result[SUB_LO +: BYTE_W], out_result[SUB_LO+WORD_W-1 : SUB_LO+2*BYTE_W]});
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KX_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: ACCEPT, STREAM, DRAIN, WAIT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KX_IDLE:   state_d = in_valid ? KX_LOADED : KX_IDLE;
            KX_LOADED: state_d = in_valid ? KX_LOADED : KX_IDLE;
            default:   state_d = KX_IDLE;
        endcase
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        out_result <= '0;
        else if (in_valid) out_result <= next_result;
    end

    always_comb begin
        out_valid = (state_q == KX_LOADED);
    end

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R8
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result));

endmodule

// File: tb/kexp_assist_tb.sv
`timescale 1ns/1ps
module kexp_assist_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] in_src = '0;
    logic [7:0]   in_rcon = '0;
    logic         out_valid;
    logic [127:0] out_result;

    int n_checks = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    kexp_assist u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_src     (in_src),
        .in_rcon    (in_rcon),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    // {rcon, word3, word2, word1, word0}
    localparam logic [135:0] VEC [4] = '{
        {8'h01, 32'h3c4fcf09, 32'h8815f7ab, 32'ha6d2ae28, 32'h16157e2b},
        {8'h00, 32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000},
        {8'h80, 32'hffffffff, 32'hffffffff, 32'hffffffff, 32'hffffffff},
        {8'h1b, 32'hff0009cf, 32'h12345678, 32'h53108001, 32'hdeadbeef}
    };

    // Known forward S-box pairs used by the vectors (R5)
    function automatic logic [7:0] ref_sbox(input logic [7:0] b);
        case (b)
            8'h00: return 8'h63;  8'h01: return 8'h7c;
            8'h09: return 8'h01;  8'h10: return 8'hca;
            8'h28: return 8'h34;  8'h3c: return 8'heb;
            8'h4f: return 8'h84;  8'h53: return 8'hed;
            8'h80: return 8'hcd;  8'ha6: return 8'h24;
            8'hae: return 8'he4;  8'hcf: return 8'h8a;
            8'hd2: return 8'hb5;  8'hff: return 8'h16;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [127:0] ref_result(input logic [127:0] src, input logic [7:0] rc);
        logic [127:0] r;
        logic [31:0]  s;
        for (int l = 0; l < 2; l++) begin
            for (int b = 0; b < 4; b++)
                s[b*8 +: 8] = ref_sbox(src[(2*l+1)*32 + b*8 +: 8]);
            r[2*l*32 +: 32]     = s;
            r[(2*l+1)*32 +: 32] = {s[7:0], s[31:8]} ^ {24'h0, rc};
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_checks++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [127:0] exp;
        logic [127:0] r_lo;
        logic [127:0] r_hi;

        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9 valid", {127'h0, out_valid}, 128'h0);
        chk("R9 result", out_result, 128'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 wait idle", {127'h0, out_valid}, 128'h0);

        // Table walk, streamed back-to-back (R10 STREAM)
        for (int i = 0; i < 4; i++) begin
            in_valid = 1'b1;
            in_src   = VEC[i][127:0];
            in_rcon  = VEC[i][135:128];
            exp = ref_result(VEC[i][127:0], VEC[i][135:128]);
            @(negedge clk);
            chk("R8 valid", {127'h0, out_valid}, 128'h1);
            chk("R1 word0", {96'h0, out_result[31:0]},   {96'h0, exp[31:0]});
            chk("R2 word2", {96'h0, out_result[95:64]},  {96'h0, exp[95:64]});
            chk("R3 word1", {96'h0, out_result[63:32]},  {96'h0, exp[63:32]});
            chk("R4 word3", {96'h0, out_result[127:96]}, {96'h0, exp[127:96]});
        end

        // R8 DRAIN: valid drops, result held
        in_valid = 1'b0;
        in_src   = '1;
        @(negedge clk);
        chk("R8 drop", {127'h0, out_valid}, 128'h0);
        chk("R8 hold", out_result, exp);

        // R4 R5: first expansion step of the standard key
        in_valid = 1'b1;
        in_src   = VEC[0][127:0];
        in_rcon  = 8'h01;
        @(negedge clk);
        chk("R4 fips temp", {96'h0, out_result[127:96]}, {96'h0, 32'h01eb848b});
        chk("R5 fips sub", {96'h0, out_result[31:0]}, {96'h0, 32'h24b5e434});

        // R5: corner bytes
        in_src = '0; in_rcon = 8'h00;
        @(negedge clk);
        chk("R5 zero", {96'h0, out_result[31:0]}, {96'h0, 32'h63636363});
        in_src = '1;
        @(negedge clk);
        chk("R5 ones", {96'h0, out_result[95:64]}, {96'h0, 32'h16161616});

        // R6: constant 0x00 vs 0xFF on the same source
        in_src = VEC[0][127:0]; in_rcon = 8'h00;
        @(negedge clk);
        r_lo = out_result;
        in_rcon = 8'hff;
        @(negedge clk);
        r_hi = out_result;
        chk("R6 upper bytes", {r_hi[127:104], r_hi[63:40]}, {r_lo[127:104], r_lo[63:40]});
        chk("R6 low byte", {r_hi[103:96] ^ r_lo[103:96], r_hi[39:32] ^ r_lo[39:32]}, 128'hffff);

        // R7: even source words replaced
        in_src  = VEC[3][127:0];
        in_rcon = 8'h1b;
        @(negedge clk);
        r_lo = out_result;
        in_src[31:0]  = 32'h0badf00d;
        in_src[95:64] = 32'hcafe1234;
        @(negedge clk);
        chk("R7 even words ignored", out_result, r_lo);

        in_valid = 1'b0;
        @(negedge clk);
        chk("R10 drain idle", {127'h0, out_valid}, 128'h0);

        finish_run();
    end

endmodule